// File: doc/BRIEF.md
# Five-Input Interrupt Mask and Priority Unit

This block collects the interrupt requests of a small 8-bit processor core. There are five request inputs, one wire each, so the core needs no external interrupt controller. One request is non-maskable. Three requests are vectored, and each has its own mask bit. The fifth is a general request that is gated only by the global enable. The unit keeps the global enable, the three mask bits and the pending state of the vectored requests. It picks the highest-priority live request and presents it to the core together with a fixed call-target address.

Software controls the unit through an 8-bit write port and reads it back through an 8-bit read port. Two strobes set and clear the global enable. When the core takes an interrupt, it pulses the acknowledge input. The unit then clears the global enable and drops the pending state of an edge-latched source. Instruction decode, stacking of the return address and bus cycles belong to the core.

The vectored requests are numbered 0 to 2. Request 2 is latched on its rising edge. Requests 0 and 1 follow their input level. The non-maskable request is also latched on its rising edge.

Top module: `irq_mask_unit`

## Requirements
- R1: After reset the global enable is 0, all three mask bits are 1 (masked), nothing is pending and `irq_valid_o` is 0. The read port then returns 8'h07.
- R2: A pulse on `ei_i` sets the global enable at the next clock edge and a pulse on `di_i` clears it. When both are high, `di_i` wins.
- R3: A write with `wr_data_i[3]`=1 loads mask bits [2:0] from `wr_data_i[2:0]`, where bit k masks vectored request k and 1 means masked. A write with `wr_data_i[3]`=0 leaves the masks unchanged.
- R4: The read port is combinational. It returns the masks in bits [2:0] and the global enable in bit 3. Bit 4 is the pending state of request 0, bit 5 that of request 1 and bit 6 that of request 2. Bit 7 is always 0.
- R5: A rising edge on `nmi_i` latches a non-maskable request. It is taken whatever the global enable and the masks are, it has vector 8'h24, and it is cleared only when acknowledged. A level held high does not re-trigger it.
- R6: A rising edge on `msk_req_i[2]` latches request 2. The latch shows as pending even while masked. It stays set until it is acknowledged or until a write with `wr_data_i[4]`=1 clears it.
- R7: Requests 0 and 1 are level sensitive, and their pending bits follow the input level.
- R8: Priority runs, highest first: non-maskable, request 2, request 1, request 0, general. A maskable or general request wins only if the global enable is 1 and, for a vectored request, its mask bit is 0. `irq_src_o` codes are 0 none, 1 non-maskable, 2 request 2, 3 request 1, 4 request 0, 5 general.
- R9: The vectors for requests 0, 1 and 2 are 8'h2C, 8'h34 and 8'h3C. With the non-maskable vector these are all multiples of 8 plus 4. The general request gives `irq_vectored_o`=0 and a vector of 8'h00.
- R10: An acknowledge while `irq_valid_o` is 1 clears the global enable and clears the latch of the winning edge-latched source.
- R11: An acknowledge while `irq_valid_o` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge latched |
| msk_req_i | input | 3 | Vectored requests 0..2 |
| gen_req_i | input | 1 | General request, level |
| ei_i | input | 1 | Global enable set strobe |
| di_i | input | 1 | Global enable clear strobe |
| wr_en_i | input | 1 | Write port strobe |
| wr_data_i | input | 8 | Write port data |
| rd_data_o | output | 8 | Read port data |
| ack_i | input | 1 | Interrupt accept strobe |
| irq_valid_o | output | 1 | A request is being presented |
| irq_src_o | output | 3 | Code of the winning source |
| irq_vec_o | output | 8 | Call-target address |
| irq_vectored_o | output | 1 | Vector is fixed (not the general request) |

## Verification
The bench sweeps all 256 combinations of mask value, vectored and general request levels, global enable and the request-2 latch. For each one it acknowledges and checks what is left behind. A wrong priority order or a mask gating the wrong request shows up as the wrong source code. A latch that is not cleared by acknowledge would show up as a stale pending bit 6. A design that lets the non-maskable request re-fire on a held level, or that leaves the enable set after an accepted interrupt, is caught by directed sequences. The same applies to one that changes masks without the enable bit, and to one that lets an idle acknowledge clear the global enable.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int NUM_MSK    = 3;
  localparam int DATA_W     = 8;
  localparam int VEC_W      = 8;
  localparam int WR_MSK_EN  = NUM_MSK;
  localparam int WR_CLR_TOP = NUM_MSK + 1;
  localparam int RD_GIE     = NUM_MSK;
  localparam int RD_PEND    = NUM_MSK + 1;
  localparam logic [VEC_W-1:0] NMI_VEC  = VEC_W'(8'h24);
  localparam logic [VEC_W-1:0] VEC_STEP = VEC_W'(8);

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_M2   = 3'd2,
    SRC_M1   = 3'd3,
    SRC_M0   = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;

  function automatic irq_src_e src_of_msk(input int k);
    return irq_src_e'(3'(int'(SRC_M0) - k));
  endfunction

  function automatic logic [VEC_W-1:0] vec_of_msk(input int k);
    return NMI_VEC + VEC_STEP * VEC_W'(k + 1);
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic rise, pend_d;

  always_comb begin
    rise   = req_i & ~prev_q;
    pend_d = rise | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);
  // R5
  edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !prev_q) |=> pend_o);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_mask_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               take_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               gie_o,
  output logic [NUM_MSK-1:0] mask_o
);
  logic               gie_q, gie_d, gie_we;
  logic [NUM_MSK-1:0] mask_q, mask_d;
  logic               mask_we;

  always_comb begin
    gie_we  = ei_i | di_i | take_i;
    gie_d   = ei_i & ~di_i & ~take_i;
    mask_we = wr_en_i & wr_data_i[WR_MSK_EN];
    mask_d  = wr_data_i[NUM_MSK-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      mask_q <= '1;
    end else begin
      if (gie_we)  gie_q  <= gie_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  assign gie_o  = gie_q;
  assign mask_o = mask_q;

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_data_i[WR_MSK_EN]) |=> $stable(mask_o));
  // R10
  take_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !gie_o);
  // R2
  di_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di_i |=> !gie_o);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_mask_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_pend_i,
  input  logic [NUM_MSK-1:0] msk_pend_i,
  input  logic               gen_req_i,
  input  logic               gie_i,
  input  logic [NUM_MSK-1:0] mask_i,
  output logic               valid_o,
  output irq_src_e           src_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vectored_o
);
  logic [NUM_MSK-1:0] live;
  logic               gen_live;

  for (genvar g = 0; g < NUM_MSK; g++) begin : g_gate
    assign live[g] = msk_pend_i[g] & ~mask_i[g] & gie_i;
  end
  assign gen_live = gen_req_i & gie_i;

  always_comb begin
    src_o      = SRC_NONE;
    vec_o      = '0;
    vectored_o = 1'b0;
    if (nmi_pend_i) begin
      src_o      = SRC_NMI;
      vec_o      = NMI_VEC;
      vectored_o = 1'b1;
    end else if (|live) begin
      for (int k = 0; k < NUM_MSK; k++) begin
        if (live[k]) begin
          src_o = src_of_msk(k);
          vec_o = vec_of_msk(k);
        end
      end
      vectored_o = 1'b1;
    end else if (gen_live) begin
      src_o = SRC_GEN;
    end
    valid_o = (src_o != SRC_NONE);
  end

  // R5
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_i |-> (src_o == SRC_NMI));
  // R8
  gie_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i && !nmi_pend_i) |-> !valid_o);
  // R9
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && vectored_o) |-> (vec_o[2:0] == 3'b100));
endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
  import irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic [2:0]        msk_req_i,
  input  logic              gen_req_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic              ack_i,
  output logic              irq_valid_o,
  output logic [2:0]        irq_src_o,
  output logic [7:0]        irq_vec_o,
  output logic              irq_vectored_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_in_n;
  logic               take, nmi_clr, top_clr;
  logic               nmi_pend, top_pend, gie;
  logic [NUM_MSK-1:0] mask, pend;
  irq_src_e           src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  always_comb begin
    take    = ack_i & irq_valid_o;
    nmi_clr = take & (src == SRC_NMI);
    top_clr = (take & (src == SRC_M2)) | (wr_en_i & wr_data_i[WR_CLR_TOP]);
  end

  irq_edge_latch u_nmi_latch (
    .clk(clk), .rst_n(rst_in_n), .req_i(nmi_i), .clr_i(nmi_clr), .pend_o(nmi_pend)
  );

  irq_edge_latch u_top_latch (
    .clk(clk), .rst_n(rst_in_n), .req_i(msk_req_i[NUM_MSK-1]), .clr_i(top_clr),
    .pend_o(top_pend)
  );

  assign pend = {top_pend, msk_req_i[NUM_MSK-2:0]};

  irq_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_in_n), .ei_i(ei_i), .di_i(di_i), .take_i(take),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .gie_o(gie), .mask_o(mask)
  );

  irq_prio_sel u_prio (
    .clk(clk), .rst_n(rst_in_n), .nmi_pend_i(nmi_pend), .msk_pend_i(pend),
    .gen_req_i(gen_req_i), .gie_i(gie), .mask_i(mask), .valid_o(irq_valid_o),
    .src_o(src), .vec_o(irq_vec_o), .vectored_o(irq_vectored_o)
  );

  assign irq_src_o = src;

  always_comb begin
    rd_data_o                            = '0;
    rd_data_o[NUM_MSK-1:0]               = mask;
    rd_data_o[RD_GIE]                    = gie;
    rd_data_o[RD_PEND +: NUM_MSK]        = pend;
  end

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    (ack_i && !irq_valid_o && !ei_i && !di_i) |=> (gie == $past(gie)));
endmodule

// File: tb/irq_mask_unit_test.sv
`timescale 1ns/1ps
module irq_mask_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       nmi_i, gen_req_i, ei_i, di_i, wr_en_i, ack_i;
  logic [2:0] msk_req_i;
  logic [7:0] wr_data_i, rd_data_o, irq_vec_o;
  logic       irq_valid_o, irq_vectored_o;
  logic [2:0] irq_src_o;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .msk_req_i(msk_req_i),
    .gen_req_i(gen_req_i), .ei_i(ei_i), .di_i(di_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ack_i(ack_i),
    .irq_valid_o(irq_valid_o), .irq_src_o(irq_src_o), .irq_vec_o(irq_vec_o),
    .irq_vectored_o(irq_vectored_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en_i = 1'b1; wr_data_i = d; step(); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse_ei(); ei_i = 1'b1; step(); ei_i = 1'b0; endtask
  task automatic pulse_di(); di_i = 1'b1; step(); di_i = 1'b0; endtask
  task automatic pulse_ack(); ack_i = 1'b1; step(); ack_i = 1'b0; endtask

  function automatic logic [7:0] exp_vec(input logic [2:0] s);
    case (s)
      3'd1: return 8'h24;
      3'd2: return 8'h3C;
      3'd3: return 8'h34;
      3'd4: return 8'h2C;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nmi_i = 0; gen_req_i = 0; ei_i = 0; di_i = 0;
    wr_en_i = 0; ack_i = 0; msk_req_i = '0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 rd", rd_data_o, 8'h07);
    chk("R1 valid", irq_valid_o, 1'b0);

    // R3 mask write without enable bit ignored, then with it
    wr(8'h05);
    chk("R3 ignored", rd_data_o[2:0], 3'b111);
    wr(8'h0D);
    chk("R3 loaded", rd_data_o[2:0], 3'b101);

    // R2 enable and disable, disable wins
    pulse_ei();
    chk("R2 ei", rd_data_o[3], 1'b1);
    ei_i = 1'b1; di_i = 1'b1; step(); ei_i = 1'b0; di_i = 1'b0;
    chk("R2 di wins", rd_data_o[3], 1'b0);

    // R11 idle ack leaves the enable alone
    wr(8'h0F); pulse_ei();
    chk("R11 idle valid", irq_valid_o, 1'b0);
    pulse_ack();
    chk("R11 gie kept", rd_data_o[3], 1'b1);

    // R7 level pending bits follow the inputs
    msk_req_i = 3'b011; #1;
    chk("R7 level hi", rd_data_o[6:4], 3'b011);
    msk_req_i = 3'b000; #1;
    chk("R7 level lo", rd_data_o[6:4], 3'b000);

    // R5 non-maskable bypasses disable and masks
    pulse_di();
    nmi_i = 1'b1; step();
    chk("R5 nmi src", irq_src_o, 3'd1);
    chk("R5 nmi vec", irq_vec_o, 8'h24);
    pulse_ack();
    chk("R5 acked", irq_valid_o, 1'b0);
    step();
    chk("R5 held level no refire", irq_valid_o, 1'b0);

    // R8 non-maskable above everything
    wr(8'h08); pulse_ei();
    msk_req_i = 3'b011; gen_req_i = 1'b1; #1;
    chk("R8 m1 wins", irq_src_o, 3'd3);
    nmi_i = 1'b0; step(); nmi_i = 1'b1; step();
    chk("R8 nmi over all", irq_src_o, 3'd1);
    pulse_ack();
    chk("R10 gie cleared", rd_data_o[3], 1'b0);
    msk_req_i = '0; gen_req_i = 1'b0; nmi_i = 1'b0;

    // R6 top latch pending while masked, then unmask, then clear by write
    wr(8'h0C);
    pulse_ei();
    msk_req_i[2] = 1'b1; step(); msk_req_i[2] = 1'b0; step();
    chk("R6 pend masked", rd_data_o[6], 1'b1);
    chk("R6 masked idle", irq_valid_o, 1'b0);
    wr(8'h08);
    chk("R6 unmasked src", irq_src_o, 3'd2);
    chk("R9 m2 vec", irq_vec_o, 8'h3C);
    wr(8'h10);
    chk("R6 write clear", rd_data_o[6], 1'b0);
    chk("R6 cleared idle", irq_valid_o, 1'b0);

    // R8 R9 R10 sweep
    for (int mm = 0; mm < 8; mm++) begin
      for (int lv = 0; lv < 8; lv++) begin
        for (int g = 0; g < 2; g++) begin
          for (int l2 = 0; l2 < 2; l2++) begin
            logic e2, e1, e0, eg, ev;
            logic [2:0] es;
            msk_req_i = '0; gen_req_i = 1'b0;
            wr(8'h18 | 8'(mm));
            if (l2 != 0) begin
              msk_req_i[2] = 1'b1; step(); msk_req_i[2] = 1'b0;
            end
            if (g != 0) pulse_ei(); else pulse_di();
            msk_req_i[1:0] = 2'(lv); gen_req_i = lv[2]; #1;
            e2 = (l2 != 0) && !mm[2] && (g != 0);
            e1 = lv[1] && !mm[1] && (g != 0);
            e0 = lv[0] && !mm[0] && (g != 0);
            eg = lv[2] && (g != 0);
            es = e2 ? 3'd2 : e1 ? 3'd3 : e0 ? 3'd4 : eg ? 3'd5 : 3'd0;
            ev = (es != 3'd0);
            chk("R8 sweep valid", irq_valid_o, ev);
            chk("R8 sweep src", irq_src_o, es);
            chk("R9 sweep vec", irq_vec_o, exp_vec(es));
            chk("R9 sweep vectored", irq_vectored_o, ev && (es != 3'd5));
            chk("R4 sweep rd", rd_data_o,
                {1'b0, 1'(l2), lv[1], lv[0], 1'(g), 3'(mm)});
            pulse_ack();
            chk("R10 sweep gie", rd_data_o[3], ev ? 1'b0 : 1'(g));
            chk("R10 sweep top pend", rd_data_o[6], (es == 3'd2) ? 1'b0 : 1'(l2));
          end
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule